// File: doc/BRIEF.md
# Two-Wire Bus Bit Sequencer

This block runs one bit-level operation at a time on a two-wire serial bus: it generates a start condition or a stop condition, or it transfers a single data bit. Data bits are either written by the master or read from the bus. A byte-level controller issues one command. It waits for the done pulse and then issues the next. Each operation runs through an idle slot and then four timed phases. Each phase lasts a number of clock cycles set by a prescaler value. In each phase the clock and data lines are set to a fixed pattern for that command.

Both lines are open drain. The block never drives a line high. It either pulls a line low (enable output low) or releases it (enable output high), and an external pull-up raises a released line. The sensed lines pass through two-flop synchronizers. The block uses them in three ways. A device holding the clock low stretches the current phase. A high data bit that reads back low means another master has taken the bus. Start and stop conditions made by any master on the bus set and clear a bus-busy flag.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both enable outputs are high (lines released), and `done`, `arb_lost` and `bus_busy` are low.
- R2: Command code 1 (start) ends with the clock line released and the data line driven low, with the data line falling while the clock line is released.
- R3: Command code 2 (stop) ends with both lines released, with the data line rising while the clock line is released.
- R4: Command code 3 (write) sets the data enable to `wr_bit` while the clock is driven low and holds it unchanged through the clock-high phases. The command ends with the clock driven low.
- R5: Command code 4 (read) releases the data line and returns in `rd_bit` the synchronized data level sampled at the end of the third phase.
- R6: With no stretching, a write accepted at clock edge E raises `done` right after edge E + 4*P + 6, where P is `presc`: four phases of P+1 cycles each, plus two cycles of synchronizer delay after the clock is released.
- R7: While the clock enable is high and the synchronized clock reads low, the phase timer stops. An external hold on the clock lengthens the operation by exactly the extra held cycles.
- R8: During a write with `wr_bit`=1, if the synchronized data reads low at a phase-end in either clock-high phase, `arb_lost` goes high and both lines are released at once. `done` is not raised. `arb_lost` clears when the next command is accepted.
- R9: `bus_busy` goes high on any start condition seen on the synchronized lines and goes low on any stop condition, whichever master made it.
- R10: `done` is high for one cycle only. A command with code 0, or any command offered while an operation is running, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Offers `cmd` for one cycle; taken only when idle |
| cmd | input | 3 | 0 none, 1 start, 2 stop, 3 write, 4 read |
| wr_bit | input | 1 | Bit to send with a write |
| presc | input | 16 | Phase length minus one, in clock cycles |
| scl_in | input | 1 | Sensed clock line |
| sda_in | input | 1 | Sensed data line |
| scl_o | output | 1 | Clock drive value (always 0) |
| scl_oen | output | 1 | Clock enable; 1 releases the line |
| sda_o | output | 1 | Data drive value (always 0) |
| sda_oen | output | 1 | Data enable; 1 releases the line |
| done | output | 1 | One-cycle pulse at the end of a command |
| rd_bit | output | 1 | Bit sampled by the last read |
| bus_busy | output | 1 | Bus taken between a start and a stop |
| arb_lost | output | 1 | Last write lost arbitration |

## Verification
A wrong phase pattern shows up within one command: the line enables left behind after `done` do not match the pattern for that command. A timer or stall fault changes the cycle count to `done` by at least one cycle, and the bench measures that count exactly. A fault in the arbitration or busy tracking shows up in `arb_lost` or `bus_busy` within a few cycles after the line event that should set it.

// File: rtl/i2cb_pkg.sv
`timescale 1ns/1ps
// Shared types for the bit sequencer: command codes, phase names,
// and the per-phase line pattern table (1 = released, 0 = pulled low).
package i2cb_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_START = 3'd1,
        CMD_STOP  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_READ  = 3'd4
    } bit_cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_A    = 3'd1,
        PH_B    = 3'd2,
        PH_C    = 3'd3,
        PH_D    = 3'd4
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    // Line pattern on entry to phase p for command c.
    function automatic lines_t phase_lines(bit_cmd_e c, phase_e p, logic b, logic scl_now);
        lines_t l;
        l.scl = 1'b1;
        l.sda = 1'b1;
        case (c)
            CMD_START: begin
                l.scl = (p == PH_A) ? scl_now : 1'b1;
                l.sda = (p == PH_A || p == PH_B);
            end
            CMD_STOP: begin
                l.scl = (p != PH_A);
                l.sda = (p == PH_D);
            end
            CMD_WRITE: begin
                l.scl = (p == PH_B || p == PH_C);
                l.sda = b;
            end
            CMD_READ: begin
                l.scl = (p == PH_B || p == PH_C);
                l.sda = 1'b1;
            end
            default: begin
                l.scl = scl_now;
                l.sda = 1'b1;
            end
        endcase
        return l;
    endfunction

    function automatic phase_e phase_next(phase_e p);
        phase_e n;
        case (p)
            PH_A:    n = PH_B;
            PH_B:    n = PH_C;
            PH_C:    n = PH_D;
            default: n = PH_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/i2cb_sync.sv
`timescale 1ns/1ps
// Brings the sensed bus lines into the clock domain through a flop chain
// of STAGES flops. It also flags start/stop conditions on the synchronized
// lines. Assumes STAGES >= 2 and idle-high lines at reset.
module i2cb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_prev;
    logic              sda_prev;

    // Shift chain for both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_raw};
            sda_ff <= {sda_ff[STAGES-2:0], sda_raw};
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    // One-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    // Data edge while the clock stays high.
    assign start_det = scl_s && scl_prev && sda_prev && !sda_s;
    assign stop_det  = scl_s && scl_prev && !sda_prev && sda_s;
endmodule

// File: rtl/i2cb_busmon.sv
`timescale 1ns/1ps
// Bus-busy flag: set by any start condition, cleared by any stop.
// Assumes detect strobes from i2cb_sync, never both in one cycle.
module i2cb_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic stop_det,
    output logic busy
);
    // Set/clear flag driven by the condition detectors.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (start_det) busy <= 1'b1;
        else if (stop_det)  busy <= 1'b0;
    end
endmodule

// File: rtl/i2cb_pacer.sv
`timescale 1ns/1ps
// Phase timer: counts presc+1 cycles per phase and freezes while hold
// is high (clock stretch). Reloads while idle, so the first phase of
// a command has full length.
module i2cb_pacer #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               hold,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [PRESC_W-1:0] cnt;

    assign tick = run && !hold && (cnt == '0);

    // Down-counter with reload at zero or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= presc;
        else if (hold)     cnt <= cnt;
        else if (cnt == '0) cnt <= presc;
        else               cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/i2cb_phase_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: takes a command while idle, steps A..D on each tick,
// sets the line enables from the pattern table, samples read data,
// and aborts on lost arbitration. Assumes ticks come from i2cb_pacer.
module i2cb_phase_fsm
    import i2cb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd,
    input  logic        wr_bit,
    input  logic        tick,
    input  logic        sda_s,
    output phase_e      phase,
    output bit_cmd_e    cmd_q,
    output lines_t      lines,
    output logic        done,
    output logic        rd_bit,
    output logic        arb_lost
);
    logic     bit_q;
    logic     accept;
    logic     lost_now;
    bit_cmd_e cmd_in;

    assign cmd_in   = bit_cmd_e'(cmd);
    assign accept   = (phase == PH_IDLE) && cmd_valid &&
                      (cmd_in inside {CMD_START, CMD_STOP, CMD_WRITE, CMD_READ});
    assign lost_now = (cmd_q == CMD_WRITE) && lines.sda && !sda_s &&
                      (phase == PH_B || phase == PH_C);

    // Phase stepping, line pattern, read sampling and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cmd_q    <= CMD_NOP;
            bit_q    <= 1'b0;
            lines    <= '{scl: 1'b1, sda: 1'b1};
            done     <= 1'b0;
            rd_bit   <= 1'b0;
            arb_lost <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                if (accept) begin
                    cmd_q    <= cmd_in;
                    bit_q    <= wr_bit;
                    arb_lost <= 1'b0;
                    phase    <= PH_A;
                    lines    <= phase_lines(cmd_in, PH_A, wr_bit, lines.scl);
                end
            end else if (tick) begin
                if (lost_now) begin
                    arb_lost <= 1'b1;
                    lines    <= '{scl: 1'b1, sda: 1'b1};
                    phase    <= PH_IDLE;
                end else if (phase == PH_D) begin
                    done  <= 1'b1;
                    phase <= PH_IDLE;
                end else begin
                    if (phase == PH_C && cmd_q == CMD_READ) rd_bit <= sda_s;
                    phase <= phase_next(phase);
                    lines <= phase_lines(cmd_q, phase_next(phase), bit_q, lines.scl);
                end
            end
        end
    end
endmodule

// File: rtl/i2c_bit_engine.sv
`timescale 1ns/1ps
// Top of the bit sequencer: joins the synchronizer, busy monitor, phase
// timer and phase sequencer. Lines are open drain: the drive values are
// tied low, and only the enables change.
module i2c_bit_engine #(
    parameter int PRESC_W   = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd,
    input  logic               wr_bit,
    input  logic [PRESC_W-1:0] presc,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_o,
    output logic               scl_oen,
    output logic               sda_o,
    output logic               sda_oen,
    output logic               done,
    output logic               rd_bit,
    output logic               bus_busy,
    output logic               arb_lost
);
    import i2cb_pkg::*;

    logic     scl_s, sda_s, start_det, stop_det;
    logic     tick, stretch;
    phase_e   phase;
    bit_cmd_e cmd_q;
    lines_t   lines;

    i2cb_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det)
    );

    i2cb_busmon u_busmon (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .busy(bus_busy)
    );

    // A released clock that still reads low is being held by another device.
    assign stretch = (phase != PH_IDLE) && lines.scl && !scl_s;

    i2cb_pacer #(.PRESC_W(PRESC_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .run(phase != PH_IDLE), .hold(stretch),
        .presc(presc), .tick(tick)
    );

    i2cb_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .wr_bit(wr_bit), .tick(tick), .sda_s(sda_s), .phase(phase),
        .cmd_q(cmd_q), .lines(lines), .done(done), .rd_bit(rd_bit),
        .arb_lost(arb_lost)
    );

    assign scl_o   = 1'b0;
    assign sda_o   = 1'b0;
    assign scl_oen = lines.scl;
    assign sda_oen = lines.sda;
endmodule

// File: rtl/i2cb_checker.sv
`timescale 1ns/1ps
// Protocol checks for i2c_bit_engine, attached with bind.
module i2cb_checker
    import i2cb_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     scl_oen,
    input logic     sda_oen,
    input logic     done,
    input logic     arb_lost,
    input logic     bus_busy,
    input logic     scl_s,
    input phase_e   phase,
    input bit_cmd_e cmd_q
);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> (scl_oen && sda_oen));

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_C && (cmd_q == CMD_WRITE || cmd_q == CMD_READ)) |-> $stable(sda_oen));

    // R7
    stretch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && scl_oen && !scl_s) |=> $stable(phase));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> $past(scl_s));

    // R2
    start_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_START && phase == PH_C) |-> scl_oen);
endmodule

bind i2c_bit_engine i2cb_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_oen(scl_oen), .sda_oen(sda_oen),
    .done(done), .arb_lost(arb_lost), .bus_busy(bus_busy), .scl_s(scl_s),
    .phase(phase), .cmd_q(cmd_q)
);

// File: tb/i2c_bit_engine_test.sv
`timescale 1ns/1ps
// Bench: bus model with pull-ups and external pull-downs, a vector table
// walked by one loop, then directed tests for timing and corner cases.
module i2c_bit_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic        wr_bit = 1'b0;
    logic [15:0] presc = 16'd4;
    logic        ext_scl_low = 1'b0;
    logic        ext_sda_low = 1'b0;
    logic        scl_o, scl_oen, sda_o, sda_oen, done, rd_bit, bus_busy, arb_lost;
    logic        scl_line, sda_line;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    // Open-drain wires with pull-ups.
    assign scl_line = (scl_oen ? 1'b1 : scl_o) & ~ext_scl_low;
    assign sda_line = (sda_oen ? 1'b1 : sda_o) & ~ext_sda_low;

    i2c_bit_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .wr_bit(wr_bit), .presc(presc), .scl_in(scl_line), .sda_in(sda_line),
        .scl_o(scl_o), .scl_oen(scl_oen), .sda_o(sda_o), .sda_oen(sda_oen),
        .done(done), .rd_bit(rd_bit), .bus_busy(bus_busy), .arb_lost(arb_lost)
    );

    // Vector: {cmd[2:0], wbit, ext_sda_low, e_scl_oen, e_sda_oen, e_rd, e_arb, e_busy}
    localparam int NV = 9;
    localparam logic [9:0] VEC [NV] = '{
        10'b001_0_0_1_0_0_0_1,  // R2 start
        10'b011_1_0_0_1_0_0_1,  // R4 write 1
        10'b011_0_0_0_0_0_0_1,  // R4 write 0
        10'b100_0_1_0_1_0_0_1,  // R5 read, bus held low
        10'b100_0_0_0_1_1_0_1,  // R5 read, bus high
        10'b001_0_0_1_0_0_0_1,  // R2 repeated start
        10'b010_0_0_1_1_0_0_0,  // R3 stop
        10'b001_0_0_1_0_0_0_1,  // R2 start
        10'b011_1_1_1_1_0_1_1   // R8 write 1 overridden
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue a command; hold_n releases the external clock hold at that
    // cycle, inj_n offers a stray stop at that cycle.
    task automatic run_cmd(input logic [2:0] c, input logic b, input int hold_n,
                           input int inj_n, output int cycles, output bit saw_done);
        @(negedge clk);
        cmd = c; wr_bit = b; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cycles = 1;
        while (!(done || arb_lost) && cycles < 5000) begin
            if (cycles == hold_n) ext_scl_low = 1'b0;
            if (cycles == inj_n) begin cmd = 3'd2; cmd_valid = 1'b1; end
            else cmd_valid = 1'b0;
            @(negedge clk);
            cycles++;
        end
        cmd_valid = 1'b0;
        saw_done = done;
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int  cyc;
        bit  sd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(scl_oen == 1'b1, "R1 scl_oen", scl_oen, 1);
        check(sda_oen == 1'b1, "R1 sda_oen", sda_oen, 1);
        check(done == 1'b0, "R1 done", done, 0);
        check(arb_lost == 1'b0, "R1 arb_lost", arb_lost, 0);
        check(bus_busy == 1'b0, "R1 bus_busy", bus_busy, 0);

        // R10: code 0 ignored
        cmd = 3'd0; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        sd = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done) sd = 1'b1;
        end
        check(sd == 1'b0, "R10 nop no done", sd, 0);
        check(scl_oen && sda_oen, "R10 nop lines", {scl_oen, sda_oen}, 3);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            logic [9:0] v;
            v = VEC[i];
            ext_sda_low = v[5];
            run_cmd(v[9:7], v[6], -1, -1, cyc, sd);
            repeat (4) @(negedge clk);
            check(cyc < 5000, $sformatf("R10 vec%0d finished", i), cyc, 0);
            check(scl_oen == v[4], $sformatf("R2/R3/R4 vec%0d scl_oen", i), scl_oen, v[4]);
            check(sda_oen == v[3], $sformatf("R2/R3/R4 vec%0d sda_oen", i), sda_oen, v[3]);
            check(arb_lost == v[1], $sformatf("R8 vec%0d arb_lost", i), arb_lost, v[1]);
            check(sd == !v[1], $sformatf("R8 vec%0d done seen", i), sd, !v[1]);
            check(bus_busy == v[0], $sformatf("R9 vec%0d bus_busy", i), bus_busy, v[0]);
            if (v[9:7] == 3'd4)
                check(rd_bit == v[2], $sformatf("R5 vec%0d rd_bit", i), rd_bit, v[2]);
            if (i != NV - 1) ext_sda_low = 1'b0;
        end

        // R9: external stop (data released while clock high) clears busy
        @(negedge clk);
        ext_sda_low = 1'b0;
        repeat (5) @(negedge clk);
        check(bus_busy == 1'b0, "R9 external stop", bus_busy, 0);

        // R6: exact write length
        presc = 16'd3;
        run_cmd(3'd1, 1'b0, -1, -1, cyc, sd);
        run_cmd(3'd3, 1'b0, -1, -1, cyc, sd);
        check(cyc == 4 * 3 + 7, "R6 write length", cyc, 4 * 3 + 7);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
        check(arb_lost == 1'b0, "R8 cleared on accept", arb_lost, 0);

        // R7: clock held low externally until cycle 20
        ext_scl_low = 1'b1;
        run_cmd(3'd3, 1'b0, 20, -1, cyc, sd);
        check(cyc == 3 * 3 + 20 + 5, "R7 stretched length", cyc, 3 * 3 + 20 + 5);
        ext_scl_low = 1'b0;

        // R10: stop offered mid-write is ignored
        run_cmd(3'd3, 1'b1, -1, 5, cyc, sd);
        check(cyc == 4 * 3 + 7, "R10 busy ignore length", cyc, 4 * 3 + 7);
        repeat (2) @(negedge clk);
        check(sda_oen == 1'b1, "R10 busy ignore sda_oen", sda_oen, 1);
        check(scl_oen == 1'b0, "R10 busy ignore scl_oen", scl_oen, 0);
        repeat (20) @(negedge clk);
        check(scl_oen == 1'b0, "R10 no late stop", scl_oen, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule